// File: doc/BRIEF.md
# Reference Frequency Quality Monitor

This block watches one incoming reference clock and judges it against a local, much faster sampling clock. It needs no configuration input. It first takes a single reference period to decide which of four nominal rates is present: 8 kHz, 1.544 MHz, 2.048 MHz or 19.44 MHz. It then counts sampling-clock cycles across a fixed number of reference edges, called a gate, and compares the total with the count expected for that rate.

Two tolerance levels apply to the gate result. Deviation past the narrow one (12 ppm by default) raises a soft out-of-range flag. Deviation past the wide one (30000 ppm by default) is treated like a reference that has stopped toggling: the block raises a holdover request, drops the detected rate and starts detection again. A line card places one instance on its primary reference and another on its secondary reference. A downstream selector reads the flags to decide which reference feeds the core loop.

The sampling clock is a parameter. The default is 160 MHz, eight times a 20 MHz master oscillator, because the 19.44 MHz class must be sampled at more than twice its rate. The gate lengths default to 1 ms, which gives an expected count of 160000. At that count one sampling cycle is worth about 6 ppm, so a 12 ppm threshold can be resolved.

Top module: `refmon_top`

## Requirements
- R1: While reset is held and right after it, rate_o = 7 (no valid rate), oor_o = 1 and hold_o = 1.
- R2: The block measures the reference period in sampling cycles, between falling edges. It then reports rate_o = 0 for 8 kHz, 1 for 1.544 MHz, 2 for 2.048 MHz or 3 for 19.44 MHz. A class is reported when the measured period lies within floor(P*HARD_PPM/1e6)+1 cycles of that class's nominal period P = floor(MCLK_HZ/REF_HZ). Where more than one class would fit, the lowest code wins. rate_o only ever changes to or from code 7.
- R3: Once a rate is detected, gates for codes 0 to 2 are timed between falling edges of the reference. Gates for code 3 are timed between rising edges. Jitter on the edge that is not used has no effect on the flags.
- R4: A gate spans GATE_EDGES reference periods of the detected class. The expected count is E = floor(MCLK_HZ*GATE_EDGES/REF_HZ). At the end of each gate, oor_o is set to 1 if |count - E| > floor(E*SOFT_PPM/1e6) and to 0 otherwise.
- R5: If |count - E| > floor(E*HARD_PPM/1e6) at the end of a gate, or if the running count passes E plus that tolerance before the gate ends, the block sets rate_o = 7, hold_o = 1 and oor_o = 1 and restarts detection.
- R6: If no edge of the kind currently in use arrives for LOSS_PERIODS*floor(MCLK_HZ/REF_HZ[0]) cycles, the block sets rate_o = 7, hold_o = 1 and oor_o = 1 and restarts detection.
- R7: oor_o falls only when a complete gate ends within the soft tolerance. hold_o falls only when a complete gate ends within the hard tolerance. Detecting a rate clears neither flag.
- R8: A reference whose period fits no class leaves rate_o = 7 and hold_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock; all counts are in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference clock under test, asynchronous to clk_i |
| rate_o | output | 3 | Detected class: 0 = 8 kHz, 1 = 1.544 MHz, 2 = 2.048 MHz, 3 = 19.44 MHz, 7 = none |
| oor_o | output | 1 | Soft out-of-range flag |
| hold_o | output | 1 | Holdover request (hard deviation, loss, or no valid rate) |

## Verification
The bench drives scaled square waves whose periods are exact multiples of the sampling clock. Exact nominal periods for each class separate the four detection windows and the per-class gate lengths. Periods one cycle long give a small deviation that separates the soft threshold from the hard one, and a period that falls between two classes checks rejection. Duty patterns that cycle through three values keep one edge periodic while the other jitters; this shows which edge each class is timed on. A period at the edge of a detection window but past the hard limit, a stopped reference, and a return from an off-frequency reference to a clean one check the holdover path, the loss timeout and the clearing of oor_o only after a full gate.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    localparam int unsigned NCLS = 4;
    localparam longint unsigned PPM_DEN = 64'd1_000_000;

    typedef enum logic [2:0] {
        RATE_8K   = 3'd0,
        RATE_1M5  = 3'd1,
        RATE_2M0  = 3'd2,
        RATE_19M  = 3'd3,
        RATE_NONE = 3'd7
    } rate_e;

    typedef enum logic {
        PH_MEASURE,
        PH_GATE
    } phase_e;

    function automatic longint unsigned lmax(input longint unsigned a, input longint unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refmon_sync.sv
module refmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref_i,
    output logic rise_o,
    output logic fall_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-1:0], ref_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/refmon_classify.sv
module refmon_classify
    import refmon_pkg::*;
#(
    parameter int unsigned CW       = 20,
    parameter int unsigned MCLK_HZ  = 160_000_000,
    parameter int unsigned REF_HZ [NCLS] = '{8_000, 1_544_000, 2_048_000, 19_440_000},
    parameter int unsigned HARD_PPM = 30_000
) (
    input  logic [CW-1:0]   period_i,
    output logic [NCLS-1:0] hit_o,
    output logic            valid_o,
    output logic [1:0]      cls_o
);
    logic [63:0] per_w;
    assign per_w = 64'(period_i);

    for (genvar k = 0; k < NCLS; k++) begin : g_win
        localparam longint unsigned PNOM = longint'(MCLK_HZ) / longint'(REF_HZ[k]);
        localparam longint unsigned TOL  = PNOM * longint'(HARD_PPM) / PPM_DEN + 64'd1;
        localparam longint unsigned LO   = (PNOM > TOL) ? PNOM - TOL : 64'd0;
        localparam longint unsigned HI   = PNOM + TOL;
        assign hit_o[k] = (per_w >= LO) && (per_w <= HI);
    end

    // lowest class index wins
    always_comb begin
        valid_o = 1'b0;
        cls_o   = '0;
        for (int k = NCLS - 1; k >= 0; k--) begin
            if (hit_o[k]) begin
                valid_o = 1'b1;
                cls_o   = 2'(k);
            end
        end
    end

endmodule

// File: rtl/refmon_judge.sv
module refmon_judge
    import refmon_pkg::*;
#(
    parameter int unsigned CW       = 20,
    parameter int unsigned EW       = 15,
    parameter int unsigned MCLK_HZ  = 160_000_000,
    parameter int unsigned REF_HZ     [NCLS] = '{8_000, 1_544_000, 2_048_000, 19_440_000},
    parameter int unsigned GATE_EDGES [NCLS] = '{8, 1_544, 2_048, 19_440},
    parameter int unsigned SOFT_PPM = 12,
    parameter int unsigned HARD_PPM = 30_000
) (
    input  logic [1:0]    cls_i,
    input  logic [CW-1:0] count_i,
    output logic [EW-1:0] edges_o,
    output logic          soft_bad_o,
    output logic          hard_bad_o,
    output logic          overrun_o
);
    logic [63:0]   exp_c  [NCLS];
    logic [63:0]   soft_c [NCLS];
    logic [63:0]   hard_c [NCLS];
    logic [EW-1:0] len_c  [NCLS];

    for (genvar k = 0; k < NCLS; k++) begin : g_cls
        localparam longint unsigned EK = longint'(MCLK_HZ) * longint'(GATE_EDGES[k]) / longint'(REF_HZ[k]);
        assign exp_c[k]  = 64'(EK);
        assign soft_c[k] = 64'(EK * longint'(SOFT_PPM) / PPM_DEN);
        assign hard_c[k] = 64'(EK * longint'(HARD_PPM) / PPM_DEN);
        assign len_c[k]  = EW'(GATE_EDGES[k]);
    end

    logic [63:0] cnt_w, dev_w, exp_w, hard_w;

    always_comb begin
        cnt_w      = 64'(count_i);
        exp_w      = exp_c[cls_i];
        hard_w     = hard_c[cls_i];
        dev_w      = (cnt_w > exp_w) ? cnt_w - exp_w : exp_w - cnt_w;
        soft_bad_o = dev_w > soft_c[cls_i];
        hard_bad_o = dev_w > hard_w;
        overrun_o  = cnt_w > exp_w + hard_w;
        edges_o    = len_c[cls_i];
    end

endmodule

// File: rtl/refmon_top.sv
module refmon_top
    import refmon_pkg::*;
#(
    parameter int unsigned MCLK_HZ      = 160_000_000,
    parameter int unsigned REF_HZ     [NCLS] = '{8_000, 1_544_000, 2_048_000, 19_440_000},
    parameter int unsigned GATE_EDGES [NCLS] = '{8, 1_544, 2_048, 19_440},
    parameter int unsigned SOFT_PPM     = 12,
    parameter int unsigned HARD_PPM     = 30_000,
    parameter int unsigned LOSS_PERIODS = 4,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ref_i,
    output logic [2:0] rate_o,
    output logic       oor_o,
    output logic       hold_o
);
    localparam longint unsigned LOSS_CYC = longint'(LOSS_PERIODS) * (longint'(MCLK_HZ) / longint'(REF_HZ[0]));
    localparam longint unsigned EXP0 = longint'(MCLK_HZ) * longint'(GATE_EDGES[0]) / longint'(REF_HZ[0]);
    localparam longint unsigned EXP1 = longint'(MCLK_HZ) * longint'(GATE_EDGES[1]) / longint'(REF_HZ[1]);
    localparam longint unsigned EXP2 = longint'(MCLK_HZ) * longint'(GATE_EDGES[2]) / longint'(REF_HZ[2]);
    localparam longint unsigned EXP3 = longint'(MCLK_HZ) * longint'(GATE_EDGES[3]) / longint'(REF_HZ[3]);
    localparam longint unsigned EXP_MAX  = lmax(lmax(EXP0, EXP1), lmax(EXP2, EXP3));
    localparam longint unsigned GATE_MAX = lmax(lmax(longint'(GATE_EDGES[0]), longint'(GATE_EDGES[1])),
                                                lmax(longint'(GATE_EDGES[2]), longint'(GATE_EDGES[3])));
    localparam int unsigned CW = $clog2(2 * EXP_MAX + LOSS_CYC + 2);
    localparam int unsigned EW = $clog2(GATE_MAX + 1);

    typedef struct packed {
        phase_e        ph;
        logic          armed;
        logic [CW-1:0] cnt;
        logic [EW-1:0] edges;
        logic [CW-1:0] sil;
        rate_e         rate;
        logic          oor;
        logic          hold;
    } st_t;

    localparam st_t ST_RST = '{ph: PH_MEASURE, armed: 1'b0, cnt: '0, edges: '0, sil: '0,
                               rate: RATE_NONE, oor: 1'b1, hold: 1'b1};

    st_t q, d;

    logic            rise, fall, sel_edge;
    logic [NCLS-1:0] hit;
    logic            cls_valid;
    logic [1:0]      cls_idx;
    logic [EW-1:0]   gate_len;
    logic            soft_bad, hard_bad, overrun;
    logic            gate_end, loss, fail;

    refmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ref_i (ref_i),
        .rise_o(rise),
        .fall_o(fall)
    );

    refmon_classify #(
        .CW(CW), .MCLK_HZ(MCLK_HZ), .REF_HZ(REF_HZ), .HARD_PPM(HARD_PPM)
    ) u_classify (
        .period_i(q.cnt),
        .hit_o   (hit),
        .valid_o (cls_valid),
        .cls_o   (cls_idx)
    );

    refmon_judge #(
        .CW(CW), .EW(EW), .MCLK_HZ(MCLK_HZ), .REF_HZ(REF_HZ), .GATE_EDGES(GATE_EDGES),
        .SOFT_PPM(SOFT_PPM), .HARD_PPM(HARD_PPM)
    ) u_judge (
        .cls_i     (q.rate[1:0]),
        .count_i   (q.cnt),
        .edges_o   (gate_len),
        .soft_bad_o(soft_bad),
        .hard_bad_o(hard_bad),
        .overrun_o (overrun)
    );

    always_comb begin
        d        = q;
        gate_end = 1'b0;
        loss     = 1'b0;
        fail     = 1'b0;
        // detection always runs on falling edges; gating on the class's own edge
        sel_edge = (q.ph == PH_GATE && q.rate == RATE_19M) ? rise : fall;
        d.sil    = sel_edge ? '0 : q.sil + 1'b1;
        d.cnt    = q.armed ? q.cnt + 1'b1 : q.cnt;

        if (!sel_edge && q.sil == CW'(LOSS_CYC - 1)) begin
            loss = 1'b1;
            fail = 1'b1;
        end else begin
            case (q.ph)
                PH_MEASURE: begin
                    if (sel_edge) begin
                        d.armed = 1'b1;
                        d.cnt   = CW'(1);
                        if (q.armed && cls_valid) begin
                            d.ph    = PH_GATE;
                            d.armed = 1'b0;
                            d.rate  = rate_e'({1'b0, cls_idx});
                        end
                    end
                end
                PH_GATE: begin
                    if (q.armed && overrun) begin
                        fail = 1'b1;
                    end else if (sel_edge) begin
                        if (!q.armed) begin
                            d.armed = 1'b1;
                            d.cnt   = CW'(1);
                            d.edges = '0;
                        end else if (q.edges + EW'(1) == gate_len) begin
                            gate_end = 1'b1;
                            if (hard_bad) begin
                                fail = 1'b1;
                            end else begin
                                d.hold  = 1'b0;
                                d.oor   = soft_bad;
                                d.cnt   = CW'(1);
                                d.edges = '0;
                            end
                        end else begin
                            d.edges = q.edges + EW'(1);
                        end
                    end
                end
                default: d = ST_RST;
            endcase
        end

        if (fail) begin
            d.ph    = PH_MEASURE;
            d.armed = 1'b0;
            d.cnt   = '0;
            d.edges = '0;
            d.rate  = RATE_NONE;
            d.hold  = 1'b1;
            d.oor   = 1'b1;
            if (loss) d.sil = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= ST_RST;
        else         q <= d;
    end

    assign rate_o = q.rate;
    assign oor_o  = q.oor;
    assign hold_o = q.hold;

    AST_ONE_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(hit)); // R2
    AST_RATE_VIA_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_o != $past(rate_o)) |-> ($past(rate_o) == RATE_NONE || rate_o == RATE_NONE)); // R2
    AST_HARD_IMPLIES_SOFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hard_bad |-> soft_bad); // R5
    AST_LOSS_FORCES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.sil == CW'(LOSS_CYC - 1) && !sel_edge) |=> (rate_o == RATE_NONE && hold_o && oor_o)); // R6
    AST_OOR_CLEARS_AT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(oor_o) |-> $past(gate_end)); // R7
    AST_HOLD_CLEARS_AT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(hold_o) |-> $past(gate_end && !hard_bad)); // R7
    AST_NONE_MEANS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rate_o == RATE_NONE) |-> hold_o); // R8

endmodule

// File: tb/tb_refmon_top.sv
module tb_refmon_top;
    timeunit 1ns;
    timeprecision 1ps;

    // scaled classes: periods 1000, 100, 40, 10 cycles; every expected gate count 4000 or 2000
    localparam int unsigned MCLK = 1_000_000;
    localparam int unsigned RHZ [4] = '{1_000, 10_000, 25_000, 100_000};
    localparam int unsigned GED [4] = '{4, 20, 50, 200};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_w = 1'b0;
    logic [2:0] rate_o;
    logic       oor_o, hold_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int hi_a [3] = '{5, 5, 5};
    int lo_a [3] = '{5, 5, 5};
    bit gen_on = 1'b0;

    refmon_top #(
        .MCLK_HZ(MCLK), .REF_HZ(RHZ), .GATE_EDGES(GED),
        .SOFT_PPM(12), .HARD_PPM(30_000), .LOSS_PERIODS(4), .SYNC_STAGES(2)
    ) dut (
        .clk_i (clk),
        .rst_ni(rst_n),
        .ref_i (ref_w),
        .rate_o(rate_o),
        .oor_o (oor_o),
        .hold_o(hold_o)
    );

    always #2.5 clk = ~clk;

    // reference generator: high for hi_a[i], low for lo_a[i], cycling i = 0..2
    initial begin
        forever begin
            if (!gen_on) begin
                @(negedge clk);
            end else begin
                for (int i = 0; i < 3; i++) begin
                    ref_w = 1'b1;
                    repeat (hi_a[i]) @(negedge clk);
                    ref_w = 1'b0;
                    repeat (lo_a[i]) @(negedge clk);
                end
            end
        end
    end

    typedef struct packed {
        int hi;
        int lo;
        int rate;
        int oor;
        int hold;
    } row_t;

    localparam int NROWS = 8;
    localparam row_t ROWS [NROWS] = '{
        '{500, 500, 0, 0, 0},
        '{ 50,  50, 1, 0, 0},
        '{ 20,  20, 2, 0, 0},
        '{  5,   5, 3, 0, 0},
        '{ 50,  51, 1, 1, 0},
        '{ 20,  21, 2, 1, 0},
        '{ 35,  35, 7, 1, 1},
        '{500, 501, 0, 1, 0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wave(input int h0, input int l0, input int h1, input int l1, input int h2, input int l2);
        hi_a = '{h0, h1, h2};
        lo_a = '{l0, l1, l2};
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        int saw_none;
        int k;
        wait_cyc(5);
        // R1: values during reset
        chk("R1", "rate in reset", int'(rate_o), 7);
        chk("R1", "oor in reset", int'(oor_o), 1);
        chk("R1", "hold in reset", int'(hold_o), 1);
        rst_n = 1'b1;
        wait_cyc(3);
        chk("R1", "hold after reset", int'(hold_o), 1);
        chk("R1", "rate after reset", int'(rate_o), 7);

        // table walk: R2 detection, R4 soft flag, R7 hold clearing, R8 rejection
        for (int r = 0; r < NROWS; r++) begin
            wave(ROWS[r].hi, ROWS[r].lo, ROWS[r].hi, ROWS[r].lo, ROWS[r].hi, ROWS[r].lo);
            gen_on = 1'b1;
            wait_cyc(9000);
            chk((ROWS[r].rate == 7) ? "R8" : "R2", $sformatf("row %0d rate", r), int'(rate_o), ROWS[r].rate);
            chk("R4", $sformatf("row %0d oor", r), int'(oor_o), ROWS[r].oor);
            chk((ROWS[r].hold == 1) ? "R8" : "R7", $sformatf("row %0d hold", r), int'(hold_o), ROWS[r].hold);
        end

        // R3: class 1 timed on falling edges; rising edges jitter, falling stay periodic
        wave(50, 50, 50, 50, 50, 50);
        wait_cyc(9000);
        chk("R3", "class1 locked", int'(rate_o), 1);
        wave(60, 60, 40, 50, 50, 40);
        wait_cyc(8000);
        chk("R3", "class1 rise jitter oor", int'(oor_o), 0);
        chk("R3", "class1 rise jitter rate", int'(rate_o), 1);

        // R3: class 3 timed on rising edges; falling edges jitter, rising stay periodic
        wave(5, 5, 5, 5, 5, 5);
        wait_cyc(9000);
        chk("R3", "class3 locked", int'(rate_o), 3);
        wave(3, 7, 7, 3, 5, 5);
        wait_cyc(8000);
        chk("R3", "class3 fall jitter oor", int'(oor_o), 0);
        chk("R3", "class3 fall jitter hold", int'(hold_o), 0);

        // R5: period 104 fits the class 1 window but deviates beyond the hard limit
        wave(50, 50, 50, 50, 50, 50);
        wait_cyc(9000);
        chk("R5", "clean before hard step", int'(hold_o), 0);
        wave(52, 52, 52, 52, 52, 52);
        saw_none = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (rate_o == 3'd7) saw_none = 1;
        end
        chk("R5", "rate dropped to none", saw_none, 1);
        chk("R5", "hold after hard step", int'(hold_o), 1);
        chk("R5", "oor after hard step", int'(oor_o), 1);

        // R7: oor clears no sooner than one complete clean gate (20 x 100 cycles)
        wave(50, 51, 50, 51, 50, 51);
        wait_cyc(9000);
        chk("R7", "soft state before recovery", int'(oor_o), 1);
        chk("R7", "hold clear in soft state", int'(hold_o), 0);
        wave(50, 50, 50, 50, 50, 50);
        k = 0;
        while (oor_o == 1'b1 && k < 6000) begin
            @(negedge clk);
            k++;
        end
        chk("R7", "oor cleared within window", int'(k < 6000), 1);
        chk("R7", "oor held for a full gate", int'(k >= 1990), 1);

        // R6: reference stops toggling
        wave(20, 20, 20, 20, 20, 20);
        wait_cyc(9000);
        chk("R6", "class2 before stop", int'(rate_o), 2);
        gen_on = 1'b0;
        wait_cyc(4500);
        chk("R6", "rate after stop", int'(rate_o), 7);
        chk("R6", "hold after stop", int'(hold_o), 1);
        chk("R6", "oor after stop", int'(oor_o), 1);
        wait_cyc(2000);
        chk("R6", "hold stays while silent", int'(hold_o), 1);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (195_000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            finish_run();
        end
    end

endmodule